// File: doc/BRIEF.md
# Strobed Pull Resistor Configuration Latch

This block keeps a two-bit pull setting (off, pull-down or pull-up) for every pin of a GPIO port and drives those settings to the pad ring. Software never writes a pin's setting directly. It first writes one shared control value, lets that value settle for a minimum setup interval, and then writes a bank's strobe mask. Every pin whose mask bit changes from 0 to 1 copies the shared control value into its own pull state. Every other pin keeps what it had.

Capture depends on the edge of the mask bit and not on its level. A mask bit that stays high captures nothing more, even when the control value later changes. A strobe that arrives before the control value has been stable for the setup interval is dropped, and the block raises a sticky setup-violation flag. A debug read port returns the stored state of any one pin.

Top module: `pull_strobe_latch`

## Requirements
- R1: After reset every pin's pull state is off (0), `setup_err_o` is 0, and the control value and both strobe masks are 0.
- R2: A write to address 0 loads the control value from `wr_data[1:0]`, with 0 = off, 1 = pull-down and 2 = pull-up. A written 3 is stored as off.
- R3: The strobe mask of bank b is at address 1+b. Bit j of that mask belongs to pin 32·b+j. Mask bits that name no existing pin (bank 1, bits 22 to 31) have no effect.
- R4: A pin loads the current control value when its mask bit goes from 0 to 1 in a mask write, provided that write lands at least SETUP_CYCLES (150) clock edges after the edge at which the control value last changed.
- R5: A 0-to-1 mask transition that lands fewer than SETUP_CYCLES edges after the last control change leaves all pull states unchanged and sets `setup_err_o` at that edge.
- R6: A mask bit written 1 while already 1, or cleared from 1 to 0, captures nothing. A control change while a mask bit is held high does not alter that pin's state.
- R7: A pin whose mask bit does not rise keeps its previous pull state, whatever the control value does.
- R8: Rewriting the control register with the value it already holds does not restart the setup interval.
- R9: `dbg_pull_o` shows the state of the pin chosen by `dbg_sel` in the same cycle. A selection of 54 or above reads 0.
- R10: `pull_o[2i+1:2i]` carries the pull state of pin i. A pull state never takes the value 3.
- R11: Once set, `setup_err_o` stays 1 until reset, including through later good captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 = control value, 1 + b = strobe mask of bank b |
| wr_data | input | 32 | Write data |
| dbg_sel | input | 6 | Pin index for the debug read |
| dbg_pull_o | output | 2 | Pull state of the selected pin |
| pull_o | output | 108 | Pull states of all pins, two bits per pin |
| setup_err_o | output | 1 | Sticky setup-violation flag |

## Verification
The assertions check on every cycle that a pin's state moves only when it is strobed and then takes the previous control value. They also check that an early strobe sets the violation flag, that the flag never drops, that no state holds the value 3, and that the setup counter restarts on a real control change and stays bounded. Only the bench scenarios can show the exact 150-edge boundary from the software side. The same holds for the bank and bit numbering, the handling of absent pins in bank 1, a same-value rewrite leaving the interval intact, and a held-high mask ignoring later control changes.

// File: rtl/pullcfg_pkg.sv
package pullcfg_pkg;

  typedef enum logic [1:0] {
    PULL_OFF  = 2'd0,
    PULL_DOWN = 2'd1,
    PULL_UP   = 2'd2
  } pull_e;

  // Map the unused code onto off, so that a stored state is never 3.
  function automatic logic [1:0] legal_pull(input logic [1:0] raw);
    return (raw == 2'd3) ? PULL_OFF : raw;
  endfunction

  // Number of pins that really exist in bank b.
  function automatic int live_bits(input int pins, input int per_bank, input int b);
    int rest;
    rest = pins - b * per_bank;
    return (rest > per_bank) ? per_bank : rest;
  endfunction

endpackage

// File: rtl/pull_ctrl_timer.sv
module pull_ctrl_timer #(
  parameter int SETUP_CYCLES = 150,
  localparam int CNT_W = $clog2(SETUP_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [1:0] ctrl_raw,
  output logic [1:0] ctrl_q,
  output logic       setup_ok
);
  import pullcfg_pkg::*;

  logic [1:0]       ctrl_new;
  logic             ctrl_change;
  logic [CNT_W-1:0] age_q;

  assign ctrl_new    = legal_pull(ctrl_raw);
  assign ctrl_change = ctrl_wr && (ctrl_new != ctrl_q);

  // age_q counts the edges since the control value last changed (1 at the change edge).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= PULL_OFF;
      age_q  <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_new;
      if (ctrl_change)                          age_q <= CNT_W'(1);
      else if (age_q < CNT_W'(SETUP_CYCLES))    age_q <= age_q + CNT_W'(1);
    end
  end

  assign setup_ok = (age_q >= CNT_W'(SETUP_CYCLES));

  p_age_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    age_q <= CNT_W'(SETUP_CYCLES));

  generate
    if (SETUP_CYCLES > 1) begin : g_restart_chk
      p_change_restarts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_change |=> !setup_ok);
    end
  endgenerate

  p_same_value_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !ctrl_change && setup_ok) |=> setup_ok);

endmodule

// File: rtl/pull_mask_bank.sv
module pull_mask_bank #(
  parameter int LIVE = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mask_wr,
  input  logic [LIVE-1:0] mask_data,
  output logic [LIVE-1:0] rise
);
  logic [LIVE-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= mask_data;
  end

  assign rise = mask_wr ? (mask_data & ~mask_q) : '0;

  p_rise_needs_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((mask_q & $past(rise)) == $past(rise)));

  p_quiet_without_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q));

endmodule

// File: rtl/pull_strobe_latch.sv
module pull_strobe_latch #(
  parameter int NUM_PINS     = 54,
  parameter int BANK_W       = 32,
  parameter int SETUP_CYCLES = 150,
  localparam int NUM_BANKS   = (NUM_PINS + BANK_W - 1) / BANK_W,
  localparam int ADDR_W      = $clog2(NUM_BANKS + 1),
  localparam int SEL_W       = $clog2(NUM_PINS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [BANK_W-1:0]     wr_data,
  input  logic [SEL_W-1:0]      dbg_sel,
  output logic [1:0]            dbg_pull_o,
  output logic [2*NUM_PINS-1:0] pull_o,
  output logic                  setup_err_o
);
  import pullcfg_pkg::*;

  logic [1:0]          ctrl_q;
  logic                setup_ok;
  logic [NUM_PINS-1:0] pin_rise;
  logic [NUM_PINS-1:0] cap;
  logic                early_strobe;
  logic [1:0]          pull_q [NUM_PINS];

  pull_ctrl_timer #(.SETUP_CYCLES(SETUP_CYCLES)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl_wr  (wr_en && (wr_addr == '0)),
    .ctrl_raw (wr_data[1:0]),
    .ctrl_q   (ctrl_q),
    .setup_ok (setup_ok)
  );

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      localparam int LIVE = live_bits(NUM_PINS, BANK_W, b);
      logic [LIVE-1:0] bank_rise;
      pull_mask_bank #(.LIVE(LIVE)) i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .mask_wr   (wr_en && (wr_addr == ADDR_W'(b + 1))),
        .mask_data (wr_data[LIVE-1:0]),
        .rise      (bank_rise)
      );
      assign pin_rise[b*BANK_W +: LIVE] = bank_rise;
    end
  endgenerate

  assign cap          = setup_ok ? pin_rise : '0;
  assign early_strobe = (pin_rise != '0) && !setup_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            setup_err_o <= 1'b0;
    else if (early_strobe) setup_err_o <= 1'b1;
  end

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pull_q[i] <= PULL_OFF;
        else if (cap[i]) pull_q[i] <= ctrl_q;
      end
      assign pull_o[2*i +: 2] = pull_q[i];

      p_hold_unstrobed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cap[i] |=> $stable(pull_q[i]));
      p_capture_value_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cap[i] |=> (pull_q[i] == $past(ctrl_q)));
      p_legal_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pull_q[i] != 2'd3);
    end
  endgenerate

  always_comb begin
    dbg_pull_o = PULL_OFF;
    for (int i = 0; i < NUM_PINS; i++)
      if (dbg_sel == SEL_W'(i)) dbg_pull_o = pull_q[i];
  end

  p_early_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    early_strobe |=> setup_err_o);
  p_flag_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    setup_err_o |=> setup_err_o);

endmodule

// File: tb/test_pull_strobe_latch.sv
`timescale 1ns/1ps
module test_pull_strobe_latch;
  localparam int NP = 54;
  localparam int S  = 150;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          wr_en = 0;
  logic [1:0]    wr_addr = 0;
  logic [31:0]   wr_data = 0;
  logic [5:0]    dbg_sel = 0;
  logic [1:0]    dbg_pull_o;
  logic [2*NP-1:0] pull_o;
  logic          setup_err_o;

  int errors = 0;
  int checks = 0;
  logic [1:0] exp_st [NP];

  always #2.5 clk = ~clk;

  pull_strobe_latch i_pull_strobe_latch (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .dbg_sel(dbg_sel), .dbg_pull_o(dbg_pull_o), .pull_o(pull_o), .setup_err_o(setup_err_o)
  );

  // Called at a falling edge; the write lands at the next rising edge.
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_data = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_pins(input string tag);
    logic [2*NP-1:0] e;
    for (int i = 0; i < NP; i++) e[2*i +: 2] = exp_st[i];
    checks++;
    if (pull_o !== e) begin
      errors++;
      $display("FAIL %s pull_o act=%h exp=%h", tag, pull_o, e);
    end
  endtask

  task automatic check_err(input string tag, input logic e);
    checks++;
    if (setup_err_o !== e) begin
      errors++;
      $display("FAIL %s setup_err act=%b exp=%b", tag, setup_err_o, e);
    end
  endtask

  task automatic check_dbg(input string tag, input logic [5:0] sel, input logic [1:0] e);
    dbg_sel = sel;
    #1;
    checks++;
    if (dbg_pull_o !== e) begin
      errors++;
      $display("FAIL %s dbg sel=%0d act=%0d exp=%0d", tag, sel, dbg_pull_o, e);
    end
  endtask

  task automatic clear_masks();
    wr(2'd1, 32'h0);
    wr(2'd2, 32'h0);
  endtask

  task automatic t_reset();
    for (int i = 0; i < NP; i++) exp_st[i] = 2'd0;
    check_pins("R1 reset");
    check_err("R1 reset", 1'b0);
    check_dbg("R1 reset", 6'd0, 2'd0);
  endtask

  task automatic t_basic();
    wr(2'd0, 32'd2);
    idle(S - 1);
    wr(2'd1, 32'h0000_0088);
    exp_st[3] = 2'd2; exp_st[7] = 2'd2;
    check_pins("R4 R10 pull-up at exact setup edge");
    check_err("R4 no violation", 1'b0);
    clear_masks();
  endtask

  task automatic t_bank1();
    wr(2'd0, 32'd1);
    idle(S - 1);
    wr(2'd2, 32'h8000_0100);
    exp_st[40] = 2'd1;
    check_pins("R3 bank1 bit8 and absent bit31");
    check_err("R3 absent bit harmless", 1'b0);
    check_dbg("R9 pin40", 6'd40, 2'd1);
    clear_masks();
  endtask

  task automatic t_others_hold();
    wr(2'd0, 32'd0);
    idle(20);
    wr(2'd0, 32'd1);
    idle(S - 1);
    wr(2'd1, 32'h0000_1000);
    exp_st[12] = 2'd1;
    check_pins("R7 unstrobed pins keep state");
    clear_masks();
  endtask

  task automatic t_reserved();
    wr(2'd0, 32'd3);
    idle(S - 1);
    wr(2'd1, 32'h0000_0008);
    exp_st[3] = 2'd0;
    check_pins("R2 code 3 stored as off");
    check_dbg("R2 pin3", 6'd3, 2'd0);
    clear_masks();
  endtask

  task automatic t_edge_only();
    wr(2'd0, 32'd2);
    idle(S - 1);
    wr(2'd1, 32'h0010_0000);
    exp_st[20] = 2'd2;
    check_pins("R4 pin20 up");
    wr(2'd0, 32'd0);
    idle(S - 1);
    check_pins("R6 control change with mask held high");
    wr(2'd1, 32'h0010_0000);
    check_pins("R6 mask 1 to 1");
    wr(2'd1, 32'h0);
    check_pins("R6 mask 1 to 0");
    check_err("R6 no violation", 1'b0);
    clear_masks();
  endtask

  task automatic t_early();
    wr(2'd0, 32'd1);
    idle(S - 2);
    wr(2'd1, 32'h0200_0000);
    check_pins("R5 strobe one edge early ignored");
    check_err("R5 violation flagged", 1'b1);
    clear_masks();
  endtask

  task automatic t_same_value();
    wr(2'd0, 32'd2);
    idle(100);
    wr(2'd0, 32'd2);
    idle(S - 102);
    wr(2'd1, 32'h4000_0000);
    exp_st[30] = 2'd2;
    check_pins("R8 rewrite same value keeps interval");
    check_err("R11 flag stays set", 1'b1);
    clear_masks();
  endtask

  task automatic t_dbg();
    check_dbg("R9 out of range", 6'd63, 2'd0);
    check_dbg("R9 pin30", 6'd30, 2'd2);
    check_dbg("R9 pin12", 6'd12, 2'd1);
    check_err("R11 after idle", 1'b1);
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_bank1();
    t_others_hold();
    t_reserved();
    t_edge_only();
    t_early();
    t_same_value();
    t_dbg();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule